// File: doc/BRIEF.md
# Debug Bus Cycle Engine with Watchdog

This block runs single read and write cycles on a Wishbone-style bus for a debug command source such as a terminal command parser. Each command carries an operation, an address and write data. A read or write first asks a resident bus master for the bus through a request/grant handshake. Once the grant arrives, the block drives the cycle itself. It returns a response with the read data and a status: OK, timeout or bus error.

The block can also assert a bus reset output for a fixed number of clocks. This command needs no grant and runs no bus cycle. A watchdog ends any cycle whose acknowledge is late and reports it as a timeout, which is kept apart from a bus error reported through `err_i`. The address width, the data width, the watchdog limit, the reset pulse length and a sole-master option are all parameters. In sole-master mode the grant step is skipped.

Top module: `dbg_bus_master`

## Requirements
- R1: A command is taken on a clock where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle. Operation encoding: `cmd_op` 0 = read, 1 = write, 2 or 3 = reset pulse.
- R2: For a read or write, `bus_req` rises in the clock after the command is taken. `cyc_o` rises in the clock after `bus_gnt` is first seen high while the request is pending.
- R3: During a cycle, `cyc_o` and `stb_o` are high together. `we_o` is 1 for a write and 0 for a read. `adr_o` and `dat_o` carry the command's address and data, and `sel_o` is all ones. The cycle is held for as many clocks as the acknowledge takes.
- R4: A clock with `ack_i` high during a cycle ends the cycle with status 0 (OK). For a read, `dat_i` from that clock is returned on `rsp_rdata`.
- R5: If no `ack_i` or `err_i` is seen in `WDOG_LIMIT` cycle clocks, the cycle ends after the last of them with status 1 (timeout). An acknowledge in that last clock still counts as OK.
- R6: A clock with `err_i` high during a cycle ends the cycle with status 2 (bus error). `err_i` wins over an `ack_i` in the same clock.
- R7: A reset-pulse command drives `rst_o` high for exactly `RST_CLKS` clocks, starting the clock after the command is taken. It never raises `bus_req` or `cyc_o`, and it then responds with status 0.
- R8: With `ack_i` tied high, each cycle lasts one clock.
- R9: With `SOLE_MASTER` = 1, `bus_req` stays low and `cyc_o` rises in the clock after the command is taken, whatever `bus_gnt` is.
- R10: `bus_req` is low in the clock after the cycle ends, which hands the bus back to the resident master.
- R11: `rsp_valid` rises in the clock after a cycle or pulse ends. It stays high with `rsp_status` and `rsp_rdata` unchanged until a clock with `rsp_ready` high, and then the block returns to idle. `rsp_rdata` is zero for writes, pulses, timeouts and bus errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_op | input | 2 | 0 read, 1 write, 2/3 reset pulse |
| cmd_addr | input | ADDR_W | Cycle address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_status | output | 2 | 0 OK, 1 timeout, 2 bus error |
| rsp_rdata | output | DATA_W | Read data |
| bus_req | output | 1 | Bus request to the resident master |
| bus_gnt | input | 1 | Bus grant from the resident master |
| cyc_o | output | 1 | Bus cycle |
| stb_o | output | 1 | Bus strobe |
| we_o | output | 1 | Write enable |
| adr_o | output | ADDR_W | Bus address |
| dat_o | output | DATA_W | Bus write data |
| sel_o | output | DATA_W/8 (rounded up) | Byte selects |
| dat_i | input | DATA_W | Bus read data |
| ack_i | input | 1 | Cycle acknowledge |
| err_i | input | 1 | Cycle error |
| rst_o | output | 1 | Bus reset pulse |

## Verification
The assertions check, on every clock, the rules that hold between neighbouring clocks. A cycle only starts after a grant. An acknowledge or error ends the cycle in the next clock. The request drops when the cycle ends. The reset pulse never overlaps a request. A pending response holds steady, and the watchdog and pulse counters stay inside their limits. Other properties need a chosen stimulus, and only the bench's scenarios can show them: the exact timeout length, the priority of error over acknowledge and of acknowledge over timeout, the pulse length, the one-clock cycle with the acknowledge tied high, and sole-master operation with no grant.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CYC,
    ST_PULSE,
    ST_RESP
  } dbgm_state_e;

  localparam logic [1:0] RS_OK      = 2'd0;
  localparam logic [1:0] RS_TIMEOUT = 2'd1;
  localparam logic [1:0] RS_BUSERR  = 2'd2;
endpackage

// File: rtl/dbgm_rst_sync.sv
module dbgm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/dbgm_wdog.sv
module dbgm_wdog #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = run && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!expired) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5
  wdog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < LIMIT);
endmodule

// File: rtl/dbgm_pulse.sv
module dbgm_pulse #(
  parameter int CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int CW = (CLKS < 2) ? 1 : $clog2(CLKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  assign active = act_q;
  assign done   = act_q && (cnt_q == CW'(CLKS - 1));

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (done) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (act_q) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // R7
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < CLKS);
endmodule

// File: rtl/dbgm_ctrl.sv
module dbgm_ctrl
  import dbgm_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter bit SOLE_MASTER = 1'b0,
  localparam int SEL_W      = (DATA_W + 7) / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              cyc_o,
  output logic              stb_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] adr_o,
  output logic [DATA_W-1:0] dat_o,
  output logic [SEL_W-1:0]  sel_o,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic              wd_expired,
  output logic              pulse_start,
  input  logic              pulse_done
);
  dbgm_state_e       state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [1:0]        st_q, st_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              accept, rsp_en;

  assign accept = cmd_valid && cmd_ready;

  always_comb begin
    state_d     = state_q;
    st_d        = st_q;
    rdat_d      = rdat_q;
    rsp_en      = 1'b0;
    pulse_start = 1'b0;
    cmd_ready   = (state_q == ST_IDLE);
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (cmd_op[1]) begin
            state_d     = ST_PULSE;
            pulse_start = 1'b1;
          end else if (SOLE_MASTER) begin
            state_d = ST_CYC;
          end else begin
            state_d = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (bus_gnt) state_d = ST_CYC;
      end
      ST_CYC: begin
        if (err_i || ack_i || wd_expired) begin
          state_d = ST_RESP;
          rsp_en  = 1'b1;
          rdat_d  = '0;
          if (err_i) begin
            st_d = RS_BUSERR;
          end else if (ack_i) begin
            st_d = RS_OK;
            if (!we_q) rdat_d = dat_i;
          end else begin
            st_d = RS_TIMEOUT;
          end
        end
      end
      ST_PULSE: begin
        if (pulse_done) begin
          state_d = ST_RESP;
          rsp_en  = 1'b1;
          st_d    = RS_OK;
          rdat_d  = '0;
        end
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      adr_q   <= '0;
      wdat_q  <= '0;
      st_q    <= RS_OK;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        we_q   <= cmd_op[0];
        adr_q  <= cmd_addr;
        wdat_q <= cmd_wdata;
      end
      if (rsp_en) begin
        st_q   <= st_d;
        rdat_q <= rdat_d;
      end
    end
  end

  assign bus_req    = !SOLE_MASTER && ((state_q == ST_REQ) || (state_q == ST_CYC));
  assign cyc_o      = (state_q == ST_CYC);
  assign stb_o      = cyc_o;
  assign we_o       = we_q;
  assign adr_o      = adr_q;
  assign dat_o      = wdat_q;
  assign sel_o      = '1;
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_status = st_q;
  assign rsp_rdata  = rdat_q;

  generate
    if (!SOLE_MASTER) begin : g_shared
      // R2
      gnt_before_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_o) |-> $past(bus_gnt));
    end else begin : g_sole
      // R9
      no_req_sole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req);
    end
  endgenerate

  // R3
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_o && !ack_i && !err_i && !wd_expired) |=> (cyc_o && $stable(adr_o) && $stable(dat_o)));

  // R4
  ack_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_o && ack_i) |=> (!cyc_o && rsp_valid));

  // R6
  err_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_o && err_i) |=> (!cyc_o && rsp_status == RS_BUSERR));

  // R10
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cyc_o) |-> !bus_req);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_rdata)));
endmodule

// File: rtl/dbg_bus_master.sv
module dbg_bus_master #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int WDOG_LIMIT  = 1024,
  parameter int RST_CLKS    = 16,
  parameter bit SOLE_MASTER = 1'b0,
  localparam int SEL_W      = (DATA_W + 7) / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              cyc_o,
  output logic              stb_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] adr_o,
  output logic [DATA_W-1:0] dat_o,
  output logic [SEL_W-1:0]  sel_o,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              ack_i,
  input  logic              err_i,
  output logic              rst_o
);
  logic rst_n_s;
  logic wd_expired;
  logic pulse_start, pulse_done;

  dbgm_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  dbgm_ctrl #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SOLE_MASTER (SOLE_MASTER)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_status  (rsp_status),
    .rsp_rdata   (rsp_rdata),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .cyc_o       (cyc_o),
    .stb_o       (stb_o),
    .we_o        (we_o),
    .adr_o       (adr_o),
    .dat_o       (dat_o),
    .sel_o       (sel_o),
    .dat_i       (dat_i),
    .ack_i       (ack_i),
    .err_i       (err_i),
    .wd_expired  (wd_expired),
    .pulse_start (pulse_start),
    .pulse_done  (pulse_done)
  );

  dbgm_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .run     (cyc_o),
    .expired (wd_expired)
  );

  dbgm_pulse #(.CLKS(RST_CLKS)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .start  (pulse_start),
    .active (rst_o),
    .done   (pulse_done)
  );

  // R7
  pulse_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rst_o |-> (!bus_req && !cyc_o));
endmodule

// File: tb/dbg_bus_master_tb.sv
module dbg_bus_master_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int WL = 8;
  localparam int RC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [1:0]    rsp_status;
  logic [DW-1:0] rsp_rdata;
  logic          bus_req;
  logic          bus_gnt = 1'b0;
  logic          cyc_o, stb_o, we_o;
  logic [AW-1:0] adr_o;
  logic [DW-1:0] dat_o;
  logic [3:0]    sel_o;
  logic [DW-1:0] dat_i = '0;
  logic          ack_i = 1'b0;
  logic          err_i = 1'b0;
  logic          rst_o;

  // solo instance signals
  logic          s_valid = 1'b0;
  logic          s_ready, s_rsp_valid, s_req, s_cyc, s_stb, s_we, s_rst;
  logic [1:0]    s_status;
  logic [DW-1:0] s_rdata, s_dat_o;
  logic [AW-1:0] s_adr;
  logic [3:0]    s_sel;

  always #2.5 clk = ~clk;

  dbg_bus_master #(.ADDR_W(AW), .DATA_W(DW), .WDOG_LIMIT(WL), .RST_CLKS(RC),
                   .SOLE_MASTER(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .cyc_o(cyc_o), .stb_o(stb_o), .we_o(we_o), .adr_o(adr_o), .dat_o(dat_o),
    .sel_o(sel_o), .dat_i(dat_i), .ack_i(ack_i), .err_i(err_i), .rst_o(rst_o));

  dbg_bus_master #(.ADDR_W(AW), .DATA_W(DW), .WDOG_LIMIT(WL), .RST_CLKS(RC),
                   .SOLE_MASTER(1'b1)) u_solo (
    .clk(clk), .rst_n(rst_n), .cmd_valid(s_valid), .cmd_ready(s_ready),
    .cmd_op(2'd0), .cmd_addr(16'h0042), .cmd_wdata(32'h0),
    .rsp_valid(s_rsp_valid), .rsp_ready(1'b1), .rsp_status(s_status),
    .rsp_rdata(s_rdata), .bus_req(s_req), .bus_gnt(1'b0),
    .cyc_o(s_cyc), .stb_o(s_stb), .we_o(s_we), .adr_o(s_adr), .dat_o(s_dat_o),
    .sel_o(s_sel), .dat_i(32'hC0DE_0042), .ack_i(1'b1), .err_i(1'b0), .rst_o(s_rst));

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // slave knobs
  int gnt_lat = 0, ack_lat = 0, err_lat = -1;
  bit ack_tie = 0;
  int req_age = 0, cyc_age = 0, cyc_len = 0;

  // reference model
  int            m_state = 0;  // 0 idle,1 req,2 cyc,3 resp,4 pulse
  int            m_cnt = 0;
  logic [1:0]    m_status = 0;
  logic [DW-1:0] m_rdata = 0;
  logic          m_we = 0;
  logic [AW-1:0] m_adr = 0;
  logic [DW-1:0] m_wd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_status = 0; m_rdata = 0;
      req_age = 0; cyc_age = 0;
    end else begin
      req_age = bus_req ? req_age + 1 : 0;
      cyc_age = cyc_o ? cyc_age + 1 : 0;
      case (m_state)
        0: if (cmd_valid) begin
             m_we = cmd_op[0]; m_adr = cmd_addr; m_wd = cmd_wdata; m_cnt = 0;
             m_state = cmd_op[1] ? 4 : 1;
           end
        1: if (bus_gnt) begin m_state = 2; m_cnt = 0; end
        2: begin
             if (err_i) begin m_state = 3; m_status = 2; m_rdata = 0; end
             else if (ack_i) begin m_state = 3; m_status = 0; m_rdata = m_we ? 0 : dat_i; end
             else if (m_cnt == WL - 1) begin m_state = 3; m_status = 1; m_rdata = 0; end
             else m_cnt++;
           end
        4: if (m_cnt == RC - 1) begin m_state = 3; m_status = 0; m_rdata = 0; end
           else m_cnt++;
        3: if (rsp_ready) m_state = 0;
        default: m_state = 0;
      endcase
    end
  end

  // compare every clock, then drive slave inputs
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 cmd_ready", cmd_ready, m_state == 0);
      chk("R2/R10 bus_req", bus_req, m_state == 1 || m_state == 2);
      chk("R3 cyc_o", cyc_o, m_state == 2);
      chk("R3 stb_o", stb_o, m_state == 2);
      chk("R7 rst_o", rst_o, m_state == 4);
      chk("R11 rsp_valid", rsp_valid, m_state == 3);
      if (m_state == 2) begin
        chk("R3 adr_o", adr_o, m_adr);
        chk("R3 we_o", we_o, m_we);
        chk("R3 dat_o", dat_o, m_wd);
        chk("R3 sel_o", sel_o, 4'hF);
      end
      if (m_state == 3) begin
        chk("R4/R5/R6 rsp_status", rsp_status, m_status);
        chk("R4/R11 rsp_rdata", rsp_rdata, m_rdata);
      end
      if (cyc_o) cyc_len++;
    end
    bus_gnt = bus_req && gnt_lat >= 0 && req_age >= gnt_lat;
    ack_i   = ack_tie ? 1'b1 : (cyc_o && cyc_age == ack_lat);
    err_i   = cyc_o && cyc_age == err_lat;
    dat_i   = 32'hA500_0000 ^ {16'h0, adr_o} ^ {24'h0, 8'(cyc_age)};
  end

  task automatic run_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int hold_rsp);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    cyc_len = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (hold_rsp > 0) rsp_ready = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat (hold_rsp) @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 reset cmd_ready", cmd_ready, 1);
    chk("R2 reset bus_req", bus_req, 0);
    chk("R3 reset cyc_o", cyc_o, 0);
    chk("R7 reset rst_o", rst_o, 0);
    chk("R11 reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R4: read, grant after 2, ack after 3
    gnt_lat = 2; ack_lat = 3; err_lat = -1;
    run_cmd(2'd0, 16'h1234, 32'h0, 0);
    // R3: write, immediate grant and ack
    gnt_lat = 0; ack_lat = 0;
    run_cmd(2'd1, 16'hBEEF, 32'hDEAD_0001, 0);
    // R5: timeout
    gnt_lat = 1; ack_lat = -1;
    run_cmd(2'd0, 16'h0010, 32'h0, 0);
    chk("R5 timeout length", cyc_len, WL);
    // R5: ack in last watchdog clock still OK
    ack_lat = WL - 1;
    run_cmd(2'd0, 16'h0020, 32'h0, 0);
    chk("R5 last-clock ack length", cyc_len, WL);
    // R6: bus error
    ack_lat = -1; err_lat = 2;
    run_cmd(2'd1, 16'h0030, 32'h5555_AAAA, 0);
    // R6: err beats ack
    ack_lat = 1; err_lat = 1;
    run_cmd(2'd0, 16'h0040, 32'h0, 0);
    // R7: reset pulse with no grant available
    gnt_lat = -1; err_lat = -1;
    run_cmd(2'd2, 16'h0, 32'h0, 0);
    chk("R7 no cycle on pulse", cyc_len, 0);
    run_cmd(2'd3, 16'h0, 32'h0, 0);
    // R11: response held
    gnt_lat = 0; ack_lat = 2;
    run_cmd(2'd0, 16'h0050, 32'h0, 3);
    // R8: ack tied high
    ack_tie = 1;
    run_cmd(2'd0, 16'h0060, 32'h0, 0);
    chk("R8 one-clock cycle", cyc_len, 1);
    run_cmd(2'd1, 16'h0070, 32'h7777_0000, 0);
    chk("R8 one-clock write", cyc_len, 1);
    ack_tie = 0;

    // R9: sole master needs no grant
    @(negedge clk);
    chk("R9 solo cmd_ready", s_ready, 1);
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    chk("R9 solo cyc_o", s_cyc, 1);
    chk("R9 solo bus_req", s_req, 0);
    @(negedge clk);
    chk("R8 solo rsp_valid", s_rsp_valid, 1);
    chk("R8 solo status", s_status, 0);
    chk("R4 solo rdata", s_rdata, 32'hC0DE_0042);
    @(negedge clk);
    chk("R11 solo back to idle", s_ready, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule